// File: doc/BRIEF.md
# Interval Timer with Interrupt Registers

This block is a small memory-mapped timer peripheral on an 8-bit register bus. A 16-bit counter steps down by one on every clock. It is reloaded from a 16-bit latch that software fills one byte at a time. When the counter sits at zero on a clock edge, the timer expires: it raises a timer flag, which can pull an active-low interrupt line, and it can toggle a square-wave output.

A control register picks the mode. In single-shot mode there is one expiry per explicit load. In free-running mode the counter reloads on every expiry, which gives a fixed period. The interrupt flags carry a computed summary bit. The interrupt enables are changed with set/clear writes. A second 16-bit counter runs down on every clock and can only be read.

The register bus has no back-pressure. A write strobe takes effect at the clock edge where it is seen. Read data is combinational from the select lines while the read strobe is high, and a read has no side effects. No valid/ready stream exists at the block's edge. Every pin is a plain control or status signal.

Top module: `itmr_top`

## Requirements
- R1: After reset the latch, both counters, the control register, flags and enables are zero. `irq_n` is 1 and `sq_out` is 0.
- R2: While `rd_en` is 1, `rd_data` returns the following by offset. 0x4/0x5 give the low/high byte of the timer counter. 0x6/0x7 give the low/high byte of the latch. 0x8/0x9 give the low/high byte of the free counter. 0xB gives the control register. Every other offset reads 0. While `rd_en` is 0, `rd_data` is 0.
- R3: A write to offset 0x4 or 0x6 changes only the latch low byte. The counter and the flags are untouched.
- R4: A write to offset 0x5 does four things. It puts the data in the latch high byte. It loads the counter with {data, latch low byte}. It clears flag bit 6. It arms one expiry.
- R5: A write to offset 0x7 puts the data in the latch high byte and clears flag bit 6. The counter is not reloaded.
- R6: The counter decrements by one per clock. An expiry happens at an edge where the counter holds zero, and it sets flag bit 6 at that edge.
- R7: Control bit 6 selects the mode.
  - 0 is single-shot: an expiry happens only while armed, and the counter wraps to 0xFFFF and keeps counting.
  - 1 is free-running: every zero is an expiry, and the counter reloads from the latch, so the period is latch+1 clocks.
- R8: Control bit 7 = 1 drives `sq_out` from a toggle bit. The toggle bit flips on each expiry and is cleared by an offset 0x5 write. Control bit 7 = 0 holds `sq_out` at 0.
- R9: Reading offset 0xD returns bits 6:0 as stored, and bit 7 = 1 when any of bits 6:0 is 1. Writing offset 0xD clears the flag bits where the data has ones.
- R10: Writing offset 0xE changes the enable bits selected by ones in data bits 6:0. Data bit 7 = 1 sets those bits and data bit 7 = 0 clears them. Reading offset 0xE returns bit 7 as 1.
- R11: `irq_n` is 0 exactly when (flags & enables) in bits 6:0 is nonzero.
- R12: When an expiry falls in the same cycle as a write to offset 0x5, 0x7 or 0xD, the flag ends set. An offset 0x5 load takes priority over the free-running reload for the counter value, and the load clears the toggle bit.
- R13: The free counter resets to 0, decrements by one every clock, wraps, and ignores all writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 4 | Register offset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe, acts at the clock edge |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, 0 when not reading |
| irq_n | output | 1 | Interrupt request, active low |
| sq_out | output | 1 | Square-wave output |

## Verification
The critical overlap is a timer expiry in the same cycle as a high-byte load at offset 0x5. Several register updates compete there: flag set against flag clear, latch reload against load value, and toggle flip against toggle clear. The bench runs the timer free-running with a short period. It clears the flag one cycle before the counter reaches zero and then issues the load on exactly the expiring edge, with a high byte that differs from the latch. It then judges the outcome at the ports: the flag reads set, the counter's high byte shows the newly loaded value rather than the reloaded one, and `sq_out` stays low.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int BUS_W   = 8;
  localparam int SEL_W   = 4;
  localparam int CNT_W   = 2 * BUS_W;
  localparam int FLAG_N  = BUS_W - 1;

  localparam logic [SEL_W-1:0] OFS_CNT_LO  = 4'h4;
  localparam logic [SEL_W-1:0] OFS_CNT_HI  = 4'h5;
  localparam logic [SEL_W-1:0] OFS_LAT_LO  = 4'h6;
  localparam logic [SEL_W-1:0] OFS_LAT_HI  = 4'h7;
  localparam logic [SEL_W-1:0] OFS_FREE_LO = 4'h8;
  localparam logic [SEL_W-1:0] OFS_FREE_HI = 4'h9;
  localparam logic [SEL_W-1:0] OFS_MODE    = 4'hB;
  localparam logic [SEL_W-1:0] OFS_FLAG    = 4'hD;
  localparam logic [SEL_W-1:0] OFS_ENA     = 4'hE;

  typedef struct packed {
    logic lat_lo;
    logic hi_load;
    logic hi_keep;
    logic mode;
    logic flag;
    logic ena;
  } wr_dec_t;
endpackage

// File: rtl/itmr_timer.sv
module itmr_timer #(
  parameter int BUS_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi_load,
  input  logic             wr_hi_keep,
  input  logic [BUS_W-1:0] wdata,
  input  logic             continuous,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] latch,
  output logic             expire,
  output logic             sq_tgl
);
  localparam int HI_W = CNT_W - BUS_W;

  logic armed;

  assign expire = (cnt == '0) && (continuous || armed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      latch  <= '0;
      armed  <= 1'b0;
      sq_tgl <= 1'b0;
    end else begin
      if (wr_lo) latch[BUS_W-1:0] <= wdata;
      if (wr_hi_load || wr_hi_keep) latch[CNT_W-1:BUS_W] <= wdata[HI_W-1:0];

      if (wr_hi_load)                cnt <= {wdata[HI_W-1:0], latch[BUS_W-1:0]};
      else if (expire && continuous) cnt <= latch;
      else                           cnt <= cnt - CNT_W'(1);

      if (wr_hi_load)  armed <= 1'b1;
      else if (expire) armed <= 1'b0;

      if (wr_hi_load)  sq_tgl <= 1'b0;
      else if (expire) sq_tgl <= ~sq_tgl;
    end
  end

  AST_HI_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi_load |=> cnt == {$past(wdata[HI_W-1:0]), $past(latch[BUS_W-1:0])}); // R4

  AST_LO_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi_load && cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1)); // R3

  AST_ONESHOT_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !continuous && !wr_hi_load) |=> cnt == '1); // R7

  AST_FREE_RUN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && continuous && !wr_hi_load) |=> cnt == $past(latch)); // R7
endmodule

// File: rtl/itmr_irq.sv
module itmr_irq #(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_set,
  input  logic             tmr_clr,
  input  logic             flag_wr,
  input  logic             ena_wr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-2:0] flags,
  output logic [BUS_W-2:0] ena,
  output logic             irq_n
);
  localparam int NI      = BUS_W - 1;
  localparam int TMR_BIT = NI - 1;
  localparam logic [NI-1:0] TMR_MASK = NI'(1) << TMR_BIT;

  logic [NI-1:0] set_vec, clr_vec, flags_nxt, ena_nxt;

  always_comb begin
    set_vec   = tmr_set ? TMR_MASK : '0;
    clr_vec   = (flag_wr ? wdata[NI-1:0] : '0) | (tmr_clr ? TMR_MASK : '0);
    flags_nxt = (flags & ~clr_vec) | set_vec;
    ena_nxt   = ena;
    if (ena_wr) begin
      if (wdata[BUS_W-1]) ena_nxt = ena | wdata[NI-1:0];
      else                ena_nxt = ena & ~wdata[NI-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      ena   <= '0;
    end else begin
      flags <= flags_nxt;
      ena   <= ena_nxt;
    end
  end

  assign irq_n = ~|(flags & ena);

  AST_FLAG_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[TMR_BIT]) |-> $past(tmr_set)); // R6

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_set && (tmr_clr || flag_wr)) |=> flags[TMR_BIT]); // R12

  AST_ENA_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_wr && wdata[BUS_W-1]) |=> (ena & $past(wdata[NI-1:0])) == $past(wdata[NI-1:0])); // R10
endmodule

// File: rtl/itmr_free.sv
module itmr_free #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt - CNT_W'(1);
  end

  AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1)); // R13
endmodule

// File: rtl/itmr_top.sv
module itmr_top
  import itmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wr_data,
  output logic [BUS_W-1:0] rd_data,
  output logic             irq_n,
  output logic             sq_out
);
  wr_dec_t             wd;
  logic [BUS_W-1:0]    mode_q;
  logic [CNT_W-1:0]    tmr_cnt, tmr_latch, free_cnt;
  logic                expire, sq_tgl;
  logic [FLAG_N-1:0]   flags, ena;

  always_comb begin
    wd         = '0;
    wd.lat_lo  = wr_en && (reg_sel == OFS_CNT_LO || reg_sel == OFS_LAT_LO);
    wd.hi_load = wr_en && (reg_sel == OFS_CNT_HI);
    wd.hi_keep = wr_en && (reg_sel == OFS_LAT_HI);
    wd.mode    = wr_en && (reg_sel == OFS_MODE);
    wd.flag    = wr_en && (reg_sel == OFS_FLAG);
    wd.ena     = wr_en && (reg_sel == OFS_ENA);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (wd.mode) mode_q <= wr_data;
  end

  itmr_timer #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_lo      (wd.lat_lo),
    .wr_hi_load (wd.hi_load),
    .wr_hi_keep (wd.hi_keep),
    .wdata      (wr_data),
    .continuous (mode_q[6]),
    .cnt        (tmr_cnt),
    .latch      (tmr_latch),
    .expire     (expire),
    .sq_tgl     (sq_tgl)
  );

  itmr_irq #(.BUS_W(BUS_W)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .tmr_set (expire),
    .tmr_clr (wd.hi_load || wd.hi_keep),
    .flag_wr (wd.flag),
    .ena_wr  (wd.ena),
    .wdata   (wr_data),
    .flags   (flags),
    .ena     (ena),
    .irq_n   (irq_n)
  );

  itmr_free #(.CNT_W(CNT_W)) u_free (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt   (free_cnt)
  );

  assign sq_out = mode_q[7] & sq_tgl;

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (reg_sel)
        OFS_CNT_LO:  rd_data = tmr_cnt[BUS_W-1:0];
        OFS_CNT_HI:  rd_data = tmr_cnt[CNT_W-1:BUS_W];
        OFS_LAT_LO:  rd_data = tmr_latch[BUS_W-1:0];
        OFS_LAT_HI:  rd_data = tmr_latch[CNT_W-1:BUS_W];
        OFS_FREE_LO: rd_data = free_cnt[BUS_W-1:0];
        OFS_FREE_HI: rd_data = free_cnt[CNT_W-1:BUS_W];
        OFS_MODE:    rd_data = mode_q;
        OFS_FLAG:    rd_data = {|flags, flags};
        OFS_ENA:     rd_data = {1'b1, ena};
        default:     rd_data = '0;
      endcase
    end
  end

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (|ena)); // R11

  AST_SQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[7] |-> !sq_out); // R8
endmodule

// File: tb/tb_itmr_top.sv
module tb_itmr_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] reg_sel = '0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq_n, sq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int unsigned ec;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  itmr_top dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_en(rd_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .irq_n(irq_n), .sq_out(sq_out)
  );

  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) ec <= 0;
    else        ec <= ec + 1;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read values while a read is on the bus
  always @(negedge clk) begin
    if (rd_en && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(rd_data, e, t);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] s, input logic [7:0] d);
    reg_sel = s; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] s, input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    reg_sel = s; rd_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] fexp;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk({7'd0, irq_n}, 8'h01, "R1 irq_n after reset");
    chk({7'd0, sq_out}, 8'h00, "R1 sq_out after reset");
    rd(4'h6, 8'h00, "R1 latch lo");
    rd(4'h7, 8'h00, "R1 latch hi");
    rd(4'hD, 8'h00, "R1 flags");
    rd(4'hE, 8'h80, "R1 R10 enables read bit7");
    rd(4'hB, 8'h00, "R1 R2 control");

    // R3/R4 latch and load
    wr(4'h6, 8'h34);
    wr(4'h5, 8'h10);               // counter = 0x1034
    wr(4'h4, 8'h77);               // counter 0x1033, latch lo 0x77
    rd(4'h4, 8'h33, "R3 counter lo unchanged by lo write");
    rd(4'h5, 8'h10, "R4 counter hi after load");
    rd(4'h6, 8'h77, "R3 latch lo");
    rd(4'h7, 8'h10, "R4 latch hi");
    rd(4'hD, 8'h00, "R3 flags untouched");

    // R6 single-shot expiry
    wr(4'hE, 8'hC0);
    wr(4'h6, 8'h05);
    wr(4'h5, 8'h00);               // counter = 5
    idle(5);
    chk({7'd0, irq_n}, 8'h01, "R6 no expiry before zero");
    rd(4'hD, 8'h00, "R6 flag clear while counter at zero");
    chk({7'd0, irq_n}, 8'h00, "R11 irq_n low after expiry");
    rd(4'hD, 8'hC0, "R6 R9 flag and summary set");
    wr(4'h7, 8'h00);               // counter 0xFFFD, flag cleared
    rd(4'h4, 8'hFD, "R5 no reload on offset 7");
    rd(4'h5, 8'hFF, "R5 R7 counter wrapped");
    rd(4'hD, 8'h00, "R5 flag cleared by offset 7");
    idle(66000);
    rd(4'hD, 8'h00, "R7 single-shot no second expiry");
    chk({7'd0, irq_n}, 8'h01, "R7 R11 irq_n stays high");

    // R7/R8 free-running with square wave
    wr(4'hB, 8'hC0);
    wr(4'h6, 8'h03);
    wr(4'h5, 8'h00);               // load 3 at E0; expiries E4, E8, E12
    idle(4);
    chk({7'd0, sq_out}, 8'h01, "R8 sq_out toggled high");
    chk({7'd0, irq_n}, 8'h00, "R11 irq_n low in free-run");
    wr(4'hD, 8'h40);               // E5
    rd(4'hD, 8'h00, "R9 flag write clears");
    idle(2);                       // post E8
    chk({7'd0, sq_out}, 8'h00, "R8 sq_out toggled low");
    rd(4'hD, 8'hC0, "R7 periodic expiry");
    rd(4'h4, 8'h02, "R7 reload from latch");
    // R12 expiry coinciding with offset 5 load
    wr(4'hD, 8'h40);               // E11: counter reaches 0
    wr(4'h5, 8'h01);               // E12: expiry and load together
    chk({7'd0, sq_out}, 8'h00, "R12 load clears toggle");
    rd(4'hD, 8'hC0, "R12 set beats clear");
    rd(4'h5, 8'h01, "R12 load beats reload");

    // R10/R11 enable set/clear
    wr(4'hE, 8'h81);
    rd(4'hE, 8'hC1, "R10 enable set");
    wr(4'hE, 8'h40);
    rd(4'hE, 8'h81, "R10 enable clear");
    chk({7'd0, irq_n}, 8'h01, "R11 masked flag no irq");
    rd(4'hD, 8'hC0, "R11 flag still stored");

    // R8 square wave disabled
    wr(4'hB, 8'h40);
    chk({7'd0, sq_out}, 8'h00, "R8 sq_out gated off");
    rd(4'hB, 8'h40, "R2 control readback");

    // R13 free counter
    wr(4'h8, 8'h55);
    fexp = 16'(0 - ec);
    rd(4'h8, fexp[7:0], "R13 free counter lo");
    fexp = 16'(0 - ec);
    rd(4'h9, fexp[15:8], "R13 free counter hi");

    // R2 unused offset and idle bus
    rd(4'h2, 8'h00, "R2 unused offset");
    reg_sel = 4'hE;
    @(negedge clk);
    chk(rd_data, 8'h00, "R2 rd_data zero without strobe");
    idle(2);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule